// File: doc/BRIEF.md
# Trace Resynchronization Counter

This block paces periodic resynchronization in an instruction trace encoder. It keeps a running count, either of the trace packets emitted or of the clock cycles that pass while tracing is active. When that count reaches a configured limit, it raises a request for a resynchronization packet. The request stays raised, and the count stays frozen, until the packet emitter sends a restart strobe. The strobe clears both.

The counting mode, the largest number of packets that can be emitted in one cycle, and the limit are all fixed at elaboration. In packet mode, the emitter reports each cycle how many packets it produced, and the whole amount is added at once. An addition that would pass the limit stops the count at the limit and raises the request on that same edge. While tracing is off, the counter holds. This stands in for the gated clock of the surrounding encoder.

Top module: `resync_pacer`

## Requirements
- R1: While rst_ni is low, resync_req_o is 0 and the internal count is zero.
- R2: In packet mode (MODE = RP_PACKETS), each rising edge with trace_on_i high, restart_i low and no request pending adds pkt_count_i to the count. All packets of one cycle are added on that one edge.
- R3: The edge on which the count would reach or pass LIMIT sets resync_req_o to 1 from that edge onward. The count saturates at LIMIT.
- R4: While resync_req_o is 1 and restart_i is low, the count does not change and resync_req_o stays 1, whatever arrives on pkt_count_i and trace_on_i.
- R5: An edge with restart_i high sets the count to zero and resync_req_o to 0.
- R6: When restart_i is high in the same cycle as a nonzero pkt_count_i, the restart wins and the count after that edge is zero, not the packet amount.
- R7: An edge with trace_on_i low and restart_i low leaves the count and resync_req_o unchanged.
- R8: In cycle mode (MODE = RP_CYCLES), each active edge (trace_on_i high, restart_i low, no request pending) adds exactly 1, and pkt_count_i has no effect.
- R9: In packet mode, a pkt_count_i value above N is treated as N.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; all state changes on the rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trace_on_i | input | 1 | Tracing active; the count is frozen while low |
| pkt_count_i | input | $clog2(N+1) | Number of packets emitted this cycle (packet mode only) |
| restart_i | input | 1 | Restart strobe from the packet emitter; clears count and request |
| resync_req_o | output | 1 | Resynchronization request, held until restart |

## Verification
Every input takes effect on the rising edge where it is sampled, so the effect of the count and the request is due one edge after the stimulus, with no extra pipeline stage. The driver applies each cycle's inputs on the falling edge and queues the request value the requirements predict after the next rising edge. The monitor compares that value a short delay after the rising edge. Results that depend on the count itself, such as the restart winning over packets, freezing, and clamping, are shown through the number of further edges needed before the request rises.

// File: rtl/resync_pacer_pkg.sv
package resync_pacer_pkg;

   typedef enum logic {
      RP_PACKETS = 1'b0,
      RP_CYCLES  = 1'b1
   } rp_mode_e;

endpackage

// File: rtl/rp_increment.sv
module rp_increment
   import resync_pacer_pkg::*;
#(
   parameter rp_mode_e MODE = RP_PACKETS,
   parameter int       N    = 4,
   parameter int       PW   = 3,
   parameter int       CW   = 5
) (
   input  logic [PW-1:0] pkt_count_i,
   input  logic          active_i,
   output logic [CW-1:0] step_o
);

   logic [CW-1:0] raw_step;

   generate
      if (MODE == RP_PACKETS) begin : g_packets
         always_comb begin
            if (pkt_count_i > PW'(N)) raw_step = CW'(N);
            else                      raw_step = CW'(pkt_count_i);
         end
      end else begin : g_cycles
         logic unused_pkt;
         assign unused_pkt = ^pkt_count_i;
         assign raw_step   = CW'(1);
      end
   endgenerate

   assign step_o = active_i ? raw_step : '0;

endmodule

// File: rtl/rp_accum.sv
module rp_accum #(
   parameter int LIMIT = 20,
   parameter int CW    = 5
) (
   input  logic [CW-1:0] count_i,
   input  logic [CW-1:0] step_i,
   output logic [CW-1:0] count_next_o,
   output logic          hit_o
);

   logic [CW-1:0] sum;

   always_comb begin
      sum          = count_i + step_i;
      hit_o        = (sum >= CW'(LIMIT));
      count_next_o = hit_o ? CW'(LIMIT) : sum;
   end

endmodule

// File: rtl/rp_state.sv
module rp_state #(
   parameter int CW = 5
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          restart_i,
   input  logic          update_i,
   input  logic [CW-1:0] count_next_i,
   input  logic          hit_i,
   output logic [CW-1:0] count_o,
   output logic          req_o
);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         count_o <= '0;
         req_o   <= 1'b0;
      end else if (restart_i) begin
         count_o <= '0;
         req_o   <= 1'b0;
      end else if (update_i) begin
         count_o <= count_next_i;
         req_o   <= hit_i;
      end
   end

endmodule

// File: rtl/resync_pacer.sv
module resync_pacer
   import resync_pacer_pkg::*;
#(
   parameter rp_mode_e MODE  = RP_PACKETS,
   parameter int       N     = 4,
   parameter int       LIMIT = 20,
   localparam int      PW    = $clog2(N + 1),
   localparam int      CW    = $clog2(LIMIT + N + 1)
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          trace_on_i,
   input  logic [PW-1:0] pkt_count_i,
   input  logic          restart_i,
   output logic          resync_req_o
);

   generate
      if (N < 1) begin : g_bad_n
         $error("resync_pacer: N must be at least 1");
      end
      if (LIMIT < 1) begin : g_bad_limit
         $error("resync_pacer: LIMIT must be at least 1");
      end
   endgenerate

   logic [CW-1:0] count_q;
   logic [CW-1:0] step;
   logic [CW-1:0] count_next;
   logic          hit;
   logic          active;

   assign active = trace_on_i && !resync_req_o;

   rp_increment #(.MODE(MODE), .N(N), .PW(PW), .CW(CW)) u_inc (
      .pkt_count_i (pkt_count_i),
      .active_i    (active),
      .step_o      (step)
   );

   rp_accum #(.LIMIT(LIMIT), .CW(CW)) u_acc (
      .count_i      (count_q),
      .step_i       (step),
      .count_next_o (count_next),
      .hit_o        (hit)
   );

   rp_state #(.CW(CW)) u_st (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .restart_i    (restart_i),
      .update_i     (active),
      .count_next_i (count_next),
      .hit_i        (hit),
      .count_o      (count_q),
      .req_o        (resync_req_o)
   );

endmodule

// File: rtl/rp_checker.sv
module rp_checker #(
   parameter int LIMIT = 20,
   parameter int CW    = 5
) (
   input logic          clk_i,
   input logic          rst_ni,
   input logic          trace_on_i,
   input logic          restart_i,
   input logic          resync_req_o,
   input logic [CW-1:0] count_q
);

   p_count_bounded_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      count_q <= CW'(LIMIT));

   p_req_rises_at_limit_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(resync_req_o) |-> count_q == CW'(LIMIT));

   p_req_held_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      resync_req_o && !restart_i |=> resync_req_o);

   p_count_frozen_pending_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      resync_req_o && !restart_i |=> $stable(count_q));

   p_restart_clears_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      restart_i |=> !resync_req_o && count_q == '0);

   p_idle_frozen_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !trace_on_i && !restart_i |=> $stable(count_q) && $stable(resync_req_o));

endmodule

bind resync_pacer rp_checker #(.LIMIT(LIMIT), .CW(CW)) u_chk (
   .clk_i        (clk_i),
   .rst_ni       (rst_ni),
   .trace_on_i   (trace_on_i),
   .restart_i    (restart_i),
   .resync_req_o (resync_req_o),
   .count_q      (count_q)
);

// File: tb/sim_resync_pacer.sv
module sim_resync_pacer;
   import resync_pacer_pkg::*;

   localparam int CLK_PERIOD = 10;
   localparam int N          = 4;
   localparam int LIMIT      = 20;
   localparam int PW         = $clog2(N + 1);

   typedef struct {
      bit    exp_pkt;
      bit    exp_cyc;
      string tag;
   } item_t;

   logic          clk = 1'b0;
   logic          rst_ni = 1'b0;
   logic          trace_on = 1'b0;
   logic [PW-1:0] pkt = '0;
   logic          restart = 1'b0;
   logic          req_pkt;
   logic          req_cyc;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   bit done   = 1'b0;

   item_t sb[$];

   int m_pc = 0;
   bit m_pr = 0;
   int m_cc = 0;
   bit m_cr = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   resync_pacer #(.MODE(RP_PACKETS), .N(N), .LIMIT(LIMIT)) u0 (
      .clk_i(clk), .rst_ni(rst_ni), .trace_on_i(trace_on),
      .pkt_count_i(pkt), .restart_i(restart), .resync_req_o(req_pkt)
   );

   resync_pacer #(.MODE(RP_CYCLES), .N(N), .LIMIT(LIMIT)) u1 (
      .clk_i(clk), .rst_ni(rst_ni), .trace_on_i(trace_on),
      .pkt_count_i(pkt), .restart_i(restart), .resync_req_o(req_cyc)
   );

   task automatic check(input bit act, input bit exp, input string what);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0b expected %0b", what, act, exp);
      end
   endtask

   task automatic drive(input bit tr, input int n, input bit rs, input string tag);
      item_t it;
      int    inc;
      @(negedge clk);
      trace_on = tr;
      pkt      = PW'(n);
      restart  = rs;
      if (rs) begin
         m_pc = 0; m_pr = 0; m_cc = 0; m_cr = 0;
      end else if (tr) begin
         if (!m_pr) begin
            inc  = (n > N) ? N : n;
            m_pc = m_pc + inc;
            if (m_pc >= LIMIT) begin m_pc = LIMIT; m_pr = 1; end
         end
         if (!m_cr) begin
            m_cc = m_cc + 1;
            if (m_cc >= LIMIT) begin m_cc = LIMIT; m_cr = 1; end
         end
      end
      it.exp_pkt = m_pr;
      it.exp_cyc = m_cr;
      it.tag     = tag;
      sb.push_back(it);
   endtask

   // monitor: compare shortly after each rising edge
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (sb.size() > 0) begin
            item_t it;
            it = sb.pop_front();
            check(req_pkt, it.exp_pkt, {it.tag, " packet-mode request"});
            check(req_cyc, it.exp_cyc, {it.tag, " cycle-mode request"});
         end
      end
   end

   // watchdog
   initial begin
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > 5000 && !done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected under 5000", cycles);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
         end
      end
   end

   initial begin
      // R1: reset state
      repeat (3) @(negedge clk);
      check(req_pkt, 1'b0, "R1 packet-mode reset");
      check(req_cyc, 1'b0, "R1 cycle-mode reset");
      rst_ni = 1'b1;

      drive(1, 0, 1, "R5");
      // R2 / R3: single packets up to the limit
      for (int i = 0; i < 19; i++) drive(1, 1, 0, "R2");
      drive(1, 1, 0, "R3");
      // R4: held while pending
      for (int i = 0; i < 5; i++) drive(1, 4, 0, "R4");
      drive(0, 4, 0, "R4");
      // R5: restart clears
      drive(1, 0, 1, "R5");
      // R7: inactive tracing ignores packets
      for (int i = 0; i < 10; i++) drive(0, 4, 0, "R7");
      // R2 multi-packet, R3 saturation on overshoot
      for (int i = 0; i < 4; i++) drive(1, 4, 0, "R2");
      drive(1, 3, 0, "R2");
      drive(1, 4, 0, "R3");
      // R6: restart beats packets in the same cycle
      drive(1, 4, 1, "R6");
      for (int i = 0; i < 4; i++) drive(1, 4, 0, "R6");
      drive(1, 3, 0, "R6");
      drive(1, 1, 0, "R6");
      // R9: values above N clamp to N
      drive(1, 0, 1, "R9");
      for (int i = 0; i < 4; i++) drive(1, 7, 0, "R9");
      drive(1, 7, 0, "R9");
      // R8: cycle mode counts edges, not packets
      drive(1, 0, 1, "R8");
      for (int i = 0; i < 20; i++) drive(1, 0, 0, "R8");
      // R7 in cycle mode: inactive edges do not count
      drive(1, 0, 1, "R7");
      for (int i = 0; i < 10; i++) drive(1, 2, 0, "R7");
      for (int i = 0; i < 30; i++) drive(0, 2, 0, "R7");
      for (int i = 0; i < 10; i++) drive(1, 0, 0, "R8");
      drive(1, 0, 0, "R4");

      @(negedge clk);
      @(negedge clk);
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule